// File: doc/BRIEF.md
# Serial Control Port with Inverted Output Latch

This block is the host-facing control interface of a frequency synthesizer. A host controller frames each transfer with a chip-enable line (`ce`). Data arrives on `di` one bit per rising edge of the serial clock `cl`. When `ce` drops, the word is kept only if exactly 36 bits were clocked in. From a kept word, seven port bits and a time-base select flag are latched. The port bits drive a seven-pin parallel output in inverted form.

The same framing serves readback. On each rising edge of `ce`, a 28-bit status value is loaded into an output shift register. It leaves on `dout`, least significant bit first, one bit per falling edge of `cl`. A free-running divider turns the reference clock into a slow, square time-base signal. When the select flag is set, port pin 0 carries that signal instead of its inverted bit.

All pins are sampled in the reference clock domain `clk` through one register stage. Serial edges are found by comparing successive samples. The host keeps `cl` and `ce` at each level for at least three reference periods.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset every `port_out` pin is 1 and `dout` is 1.
- R2: While `ce` is high, `di` is sampled on each rising edge of `cl`. Bit k of the received word is the k-th bit sent, counting from 0. Word bits 0 to 6 are the port bits O0 to O6, and word bit 7 is the time-base select flag TB.
- R3: The port bits and TB are updated on the falling edge of `ce` only when exactly 36 rising `cl` edges were counted in that frame. A frame with any other count leaves `port_out` unchanged.
- R4: `port_out[i]` equals the inverse of the latched bit Oi, for pins 1 to 6 at all times and for pin 0 while TB is 0.
- R5: While TB is 1, `port_out[0]` carries the time-base clock instead of the inverted O0 bit.
- R6: The time-base clock has a period of `TB_DIV` reference cycles (900,000 by default, which gives 8 Hz from 7.2 MHz) and a 50% duty cycle. It runs freely from reset and serial transfers do not disturb it.
- R7: On the rising edge of `ce`, `status_in` is loaded for readback, and `dout` presents status bit 0. Each falling `cl` edge inside the frame advances `dout` to the next bit. After all 28 bits have been shifted out, `dout` reads 0.
- R8: `dout` is 1 whenever `ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Transfer frame enable |
| cl | input | 1 | Serial bit clock |
| di | input | 1 | Serial data from host |
| status_in | input | 28 | Status value offered for readback |
| dout | output | 1 | Serial data to host |
| port_out | output | 7 | Inverted port bits; pin 0 optionally time base |

## Verification
The assertions assume that `ce` and `cl` never change in the same reference cycle. They also assume that each level of `ce` and `cl` is held long enough for the single sampling stage to see every edge. The count and readback properties depend on those assumptions. The bench drives each level of `cl` and `ce` for at least four reference cycles, and it changes `di` only while `cl` is low. It shortens `TB_DIV` to 20 so that whole time-base periods can be measured within the run.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int WR_BITS = 36,
  parameter int RD_BITS = 28,
  parameter int PORT_W  = 7,
  parameter int TB_DIV  = 900000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               cl,
  input  logic               di,
  input  logic [RD_BITS-1:0] status_in,
  output logic               dout,
  output logic [PORT_W-1:0]  port_out
);
  localparam int HALF = TB_DIV / 2;
  localparam int CW   = $clog2(HALF);
  localparam int NW   = $clog2(WR_BITS + 2);

  logic ce_s, ce_d, cl_s, cl_d, di_s;
  logic [NW-1:0]      nbits;
  logic [WR_BITS-1:0] wr_sr;
  logic [RD_BITS-1:0] rd_sr;
  logic [PORT_W-1:0]  o_q;
  logic               tb_en;
  logic [CW-1:0]      cnt;
  logic               tb_clk;

  wire ce_rise = ce_s & ~ce_d;
  wire ce_fall = ~ce_s & ce_d;
  wire cl_rise = ce_s & cl_s & ~cl_d;
  wire cl_fall = ce_s & ~cl_s & cl_d;
  wire commit  = ce_fall && (nbits == NW'(WR_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_s <= 1'b0; ce_d <= 1'b0;
      cl_s <= 1'b0; cl_d <= 1'b0;
      di_s <= 1'b0;
    end else begin
      ce_s <= ce;   ce_d <= ce_s;
      cl_s <= cl;   cl_d <= cl_s;
      di_s <= di;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbits <= '0;
      wr_sr <= '0;
    end else if (ce_rise) begin
      nbits <= '0;
    end else if (cl_rise) begin
      wr_sr <= {di_s, wr_sr[WR_BITS-1:1]};
      if (nbits != NW'(WR_BITS + 1)) nbits <= nbits + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_q   <= '0;
      tb_en <= 1'b0;
    end else if (commit) begin
      o_q   <= wr_sr[PORT_W-1:0];
      tb_en <= wr_sr[PORT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_sr <= '0;
    else if (ce_rise) rd_sr <= status_in;
    else if (cl_fall) rd_sr <= {1'b0, rd_sr[RD_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      tb_clk <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt    <= '0;
      tb_clk <= ~tb_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign dout                = ce_s ? rd_sr[0] : 1'b1;
  assign port_out[PORT_W-1:1] = ~o_q[PORT_W-1:1];
  assign port_out[0]          = tb_en ? tb_clk : ~o_q[0];
endmodule

// File: rtl/serial_ctl_port_chk.sv
module serial_ctl_port_chk #(
  parameter int WR_BITS = 36,
  parameter int RD_BITS = 28,
  parameter int PORT_W  = 7,
  parameter int TB_DIV  = 900000,
  parameter int NW      = 6,
  parameter int CW      = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce,
  input logic               dout,
  input logic [PORT_W-1:0]  port_out,
  input logic [RD_BITS-1:0] status_in,
  input logic [RD_BITS-1:0] rd_sr,
  input logic               ce_rise,
  input logic               commit,
  input logic [NW-1:0]      nbits,
  input logic [CW-1:0]      cnt,
  input logic               tb_clk
);
  AST_RESET_PORT: assert property (@(posedge clk) $rose(rst_n) |-> (&port_out && dout)); // R1
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) nbits <= NW'(WR_BITS + 1)); // R2
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(port_out[PORT_W-1:1])); // R3
  AST_TB_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt < CW'(TB_DIV / 2)); // R6
  AST_TB_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (tb_clk != $past(tb_clk)) |-> $past(cnt) == CW'(TB_DIV / 2 - 1)); // R6
  AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ce_rise |=> rd_sr == $past(status_in)); // R7
  AST_DO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!ce && !$past(ce)) |=> dout); // R8
endmodule

bind serial_ctl_port serial_ctl_port_chk #(
  .WR_BITS(WR_BITS), .RD_BITS(RD_BITS), .PORT_W(PORT_W), .TB_DIV(TB_DIV),
  .NW($clog2(WR_BITS + 2)), .CW($clog2(TB_DIV / 2))
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .dout(dout), .port_out(port_out),
  .status_in(status_in), .rd_sr(rd_sr), .ce_rise(ce_rise), .commit(commit),
  .nbits(nbits), .cnt(cnt), .tb_clk(tb_clk)
);

// File: tb/sim_serial_ctl_port.sv
module sim_serial_ctl_port;
  localparam int TBD = 20;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic [27:0] status_in = '0;
  logic dout;
  logic [6:0] port_out;
  int n_run = 0, n_fail = 0;
  logic [6:0] exp_o = 7'h00;
  logic exp_tb = 1'b0;

  always #2.5 clk = ~clk;

  serial_ctl_port #(.TB_DIV(TBD)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cl(cl), .di(di),
    .status_in(status_in), .dout(dout), .port_out(port_out)
  );

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic write_frame(logic [35:0] w, int n);
    ce = 1'b1; wclk(4);
    for (int i = 0; i < n; i++) begin
      di = (i < 36) ? w[i] : 1'b0;
      wclk(4); cl = 1'b1; wclk(4); cl = 1'b0;
    end
    wclk(4); ce = 1'b0; wclk(6);
    if (n == 36) begin exp_o = w[6:0]; exp_tb = w[7]; end
  endtask

  task automatic check_port(string req);
    chk(port_out[6:1] == ~exp_o[6:1], req, port_out[6:1], ~exp_o[6:1]);
    if (!exp_tb) chk(port_out[0] == ~exp_o[0], req, port_out[0], ~exp_o[0]);
  endtask

  task automatic read_frame(logic [27:0] s);
    logic q[$];
    for (int i = 0; i < 28; i++) q.push_back(s[i]);
    status_in = s;
    ce = 1'b1; wclk(6);
    chk(dout == q[0], "R7 first bit", dout, q[0]);
    for (int i = 0; i < 30; i++) begin
      cl = 1'b1; wclk(4); cl = 1'b0; wclk(6);
      if (q.size() > 0) void'(q.pop_front());
      chk(dout == ((q.size() > 0) ? q[0] : 1'b0), "R7 shift", dout, (q.size() > 0) ? q[0] : 1'b0);
    end
    status_in = ~s;
    ce = 1'b0; wclk(6);
    chk(dout == 1'b1, "R8 idle after read", dout, 1);
  endtask

  task automatic measure_tb();
    int hi = 0, lo = 0, guard = 0;
    while (port_out[0] !== 1'b0 && guard < 100) begin wclk(1); guard++; end
    while (port_out[0] !== 1'b1 && guard < 100) begin wclk(1); guard++; end
    while (port_out[0] === 1'b1 && hi < 100) begin wclk(1); hi++; end
    while (port_out[0] === 1'b0 && lo < 100) begin wclk(1); lo++; end
    chk(hi == TBD / 2, "R6 high time", hi, TBD / 2);
    chk(lo == TBD / 2, "R6 low time", lo, TBD / 2);
  endtask

  initial begin
    wclk(5);
    chk(port_out == 7'h7f, "R1 port reset", port_out, 7'h7f);
    chk(dout == 1'b1, "R1 dout reset", dout, 1);
    rst_n = 1'b1; wclk(3);
    chk(dout == 1'b1, "R8 idle", dout, 1);

    write_frame(36'h0_0000_0055, 36);
    check_port("R2 R4 word 0x55");
    write_frame(36'hA_BCDE_F02A, 36);
    check_port("R2 R4 word 0x2A");
    write_frame(36'h0_0000_007F, 35);
    check_port("R3 short frame");
    write_frame(36'h0_0000_0011, 37);
    check_port("R3 long frame");
    write_frame(36'h0_0000_0000, 36);
    check_port("R4 all zero");
    chk(port_out == 7'h7f, "R4 all zero pins", port_out, 7'h7f);

    read_frame(28'hA5C_3E71);
    read_frame(28'h800_0001);
    check_port("R3 read frame keeps port");

    write_frame(36'h0_0000_00C3, 36);
    check_port("R5 other pins with TB");
    measure_tb();
    write_frame(36'h0_0000_00C3, 36);
    measure_tb();
    check_port("R6 port after transfer");

    write_frame(36'h0_0000_0042, 36);
    check_port("R5 TB cleared");
    wclk(TBD);
    chk(port_out[0] == 1'b1, "R5 pin0 static", port_out[0], 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule